// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block moves a single word between two ports that run on unrelated clocks, without going through the FIFO queue. A writer on one clock stores a word. A reader on the other clock learns from an active-low flag that the word is waiting, and collects it with a read access. The flag is set in the writer's domain and cleared from the reader's domain. While a word is outstanding, the writer cannot overwrite it.

Each event crosses between the domains as a toggle through a chain of synchronizer flops. A write flips a toggle in the writer domain. The reader detects the flip, copies the stored word into a reader-side holding register and drives its flag low. A read that takes the mail flips a return toggle. When that flip reaches the writer domain, the writer flag is released.

The reader's data output is a multiplexer. It selects either the delivered mailbox word or the word from the FIFO output register. The block's reset stands for a master or partial reset of the associated FIFO. Reset clears both flags and the stored word.

Top module: `mbox_xclk_top`

## Requirements
- R1: A writer-clock rising edge performs a mailbox write when all four of the following hold:
  - `wr_cs_n` is 0.
  - `wr_en` is 1.
  - `wr_dir` is 1 (1 = write).
  - `wr_sel` is 1.

  If no mail is pending, the word is stored and `wr_mail_n` reads 0 after that edge. Any other combination stores nothing.
- R2: After an accepted write, `rd_mail_n` goes to 0 on the third reader-clock rising edge strictly later than the writing edge. From that same edge, `rd_data` shows the written word while `rd_sel` is 1.
- R3: While `wr_mail_n` is 0, write accesses are ignored. The word the reader later collects is the first one written.
- R4: A reader-clock rising edge performs a read access when all four of the following hold:
  - `rd_cs_n` is 0.
  - `rd_en` is 1.
  - `rd_dir` is 1 (1 = read).
  - `rd_sel` is 1.

  If `rd_mail_n` is 0, the read takes the mail and `rd_mail_n` reads 1 after that edge.
- R5: After mail is taken, `wr_mail_n` returns to 1 on the third writer-clock rising edge strictly later than the taking edge. From then on, a new write is accepted.
- R6: `rd_data` equals the delivered mailbox word when `rd_sel` is 1. It equals `fifo_q` when `rd_sel` is 0, with no clock delay in either case.
- R7: The delivered word on the reader side changes only when new mail arrives. It stays unchanged through the read that takes it and until the next delivery.
- R8: While `rst_n` is 0, both flags read 1 and the stored word reads 0. This takes effect immediately, without waiting for a clock edge.
- R9: A read access while `rd_mail_n` is 1 leaves both flags unchanged. It returns the previously delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the associated FIFO |
| wr_clk | input | 1 | Writer port clock |
| wr_cs_n | input | 1 | Writer port select, active low |
| wr_en | input | 1 | Writer port enable |
| wr_dir | input | 1 | Writer access direction, 1 = write |
| wr_sel | input | 1 | Writer targets the mailbox when 1 |
| wr_data | input | DATA_W | Word to store |
| wr_mail_n | output | 1 | Writer-domain flag, 0 while mail is outstanding |
| rd_clk | input | 1 | Reader port clock |
| rd_cs_n | input | 1 | Reader port select, active low |
| rd_en | input | 1 | Reader port enable |
| rd_dir | input | 1 | Reader access direction, 1 = read |
| rd_sel | input | 1 | Reader targets the mailbox when 1 |
| fifo_q | input | DATA_W | FIFO output register word |
| rd_data | output | DATA_W | Mailbox word or FIFO word, chosen by rd_sel |
| rd_mail_n | output | 1 | Reader-domain flag, 0 while new mail waits |

## Verification
The hardest situation to reach is a write attempt that lands inside the round trip. Such a write arrives after the reader has already taken the mail, but before the return toggle has reached the writer. Only the writer's lockout keeps it from corrupting the next word. A random-phase stress phase holds write and read strobes asserted on every cycle on two clocks of unrelated periods (5 ns and 7 ns), so these late writes fall on many phases of the handshake. A reset asserted while a word is still in flight checks that no stale toggle survives into the next transfer.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // One port access qualifies when the port is selected, enabled,
  // pointed in the given direction and aimed at the mailbox.
  function automatic logic port_hit(input logic cs_n, input logic en,
                                    input logic dir, input logic sel);
    return (!cs_n) && en && dir && sel;
  endfunction

  // A toggle crossing carries one event per change of level.
  function automatic logic toggle_seen(input logic now_v, input logic last_v);
    return now_v ^ last_v;
  endfunction

endpackage

// File: rtl/mbox_tgl_sync.sv
module mbox_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[LAST];
endmodule

// File: rtl/mbox_wr_side.sv
module mbox_wr_side
  import mbox_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              en,
  input  logic              dir,
  input  logic              sel,
  input  logic [DATA_W-1:0] din,
  input  logic              ack_tgl_async,
  output logic              set_tgl,
  output logic [DATA_W-1:0] mail_word,
  output logic              flag_n
);
  logic              wr_hit;
  logic              wr_fire;
  logic              ack_sync;
  logic              ack_last;
  logic              ack_arrive;
  logic              pend_q;
  logic              set_q;
  logic [DATA_W-1:0] mail_q;

  mbox_tgl_sync #(.STAGES(SYNC_N)) u_ack_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(ack_tgl_async),
    .q_sync (ack_sync)
  );

  assign wr_hit     = port_hit(cs_n, en, dir, sel);
  assign wr_fire    = wr_hit && !pend_q;
  assign ack_arrive = toggle_seen(ack_sync, ack_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      set_q    <= 1'b0;
      ack_last <= 1'b0;
      mail_q   <= '0;
    end else begin
      ack_last <= ack_sync;
      if (wr_fire) begin
        mail_q <= din;
        set_q  <= ~set_q;
        pend_q <= 1'b1;
      end else if (ack_arrive) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign set_tgl   = set_q;
  assign mail_word = mail_q;
  assign flag_n    = ~pend_q;

  AST_WR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !flag_n);  // R1
  AST_WR_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !flag_n) |=> ($stable(mail_q) && $stable(set_q)));  // R3
  AST_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_arrive |=> flag_n);  // R5
endmodule

// File: rtl/mbox_rd_side.sv
module mbox_rd_side
  import mbox_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              en,
  input  logic              dir,
  input  logic              sel,
  input  logic [DATA_W-1:0] fifo_q,
  input  logic [DATA_W-1:0] mail_word,
  input  logic              set_tgl_async,
  output logic              ack_tgl,
  output logic [DATA_W-1:0] dout,
  output logic              flag_n
);
  logic              rd_hit;
  logic              rd_take;
  logic              set_sync;
  logic              set_last;
  logic              set_arrive;
  logic              pend_q;
  logic              ack_q;
  logic [DATA_W-1:0] shadow_q;

  mbox_tgl_sync #(.STAGES(SYNC_N)) u_set_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(set_tgl_async),
    .q_sync (set_sync)
  );

  assign rd_hit     = port_hit(cs_n, en, dir, sel);
  assign rd_take    = rd_hit && pend_q;
  assign set_arrive = toggle_seen(set_sync, set_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      ack_q    <= 1'b0;
      set_last <= 1'b0;
      shadow_q <= '0;
    end else begin
      set_last <= set_sync;
      if (set_arrive) begin
        shadow_q <= mail_word;
        pend_q   <= 1'b1;
      end else if (rd_take) begin
        pend_q <= 1'b0;
        ack_q  <= ~ack_q;
      end
    end
  end

  assign ack_tgl = ack_q;
  assign dout    = sel ? shadow_q : fifo_q;
  assign flag_n  = ~pend_q;

  AST_RD_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
    set_arrive |=> !flag_n);  // R2
  AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_arrive, rd_take}));  // R2
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> (flag_n && !$stable(ack_q)));  // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !set_arrive |=> $stable(shadow_q));  // R7
  AST_RD_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && flag_n && !set_arrive) |=> (flag_n && $stable(ack_q)));  // R9
endmodule

// File: rtl/mbox_xclk_top.sv
module mbox_xclk_top #(
  parameter int DATA_W = 36,
  parameter int SYNC_N = 2
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_cs_n,
  input  logic              wr_en,
  input  logic              wr_dir,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_mail_n,
  input  logic              rd_clk,
  input  logic              rd_cs_n,
  input  logic              rd_en,
  input  logic              rd_dir,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] fifo_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mail_n
);
  logic              set_tgl;
  logic              ack_tgl;
  logic [DATA_W-1:0] mail_word;

  mbox_wr_side #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_wr (
    .clk          (wr_clk),
    .rst_n        (rst_n),
    .cs_n         (wr_cs_n),
    .en           (wr_en),
    .dir          (wr_dir),
    .sel          (wr_sel),
    .din          (wr_data),
    .ack_tgl_async(ack_tgl),
    .set_tgl      (set_tgl),
    .mail_word    (mail_word),
    .flag_n       (wr_mail_n)
  );

  mbox_rd_side #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_rd (
    .clk          (rd_clk),
    .rst_n        (rst_n),
    .cs_n         (rd_cs_n),
    .en           (rd_en),
    .dir          (rd_dir),
    .sel          (rd_sel),
    .fifo_q       (fifo_q),
    .mail_word    (mail_word),
    .set_tgl_async(set_tgl),
    .ack_tgl      (ack_tgl),
    .dout         (rd_data),
    .flag_n       (rd_mail_n)
  );

  AST_RESET_FLAGS: assert property (@(posedge wr_clk)
    !rst_n |-> (wr_mail_n && rd_mail_n));  // R8
endmodule

// File: tb/mbox_xclk_top_tb_top.sv
`timescale 1ns/100ps
module mbox_xclk_top_tb_top;
  localparam int DW = 36;

  logic rst_n = 1'b0;
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic w_cs_n = 1'b1, w_en = 1'b0, w_dir = 1'b0, w_sel = 1'b0;
  logic [DW-1:0] w_data = '0;
  logic r_cs_n = 1'b1, r_en = 1'b0, r_dir = 1'b0, r_sel = 1'b0;
  logic [DW-1:0] f_q = '0;
  logic wr_mail_n, rd_mail_n;
  logic [DW-1:0] rd_data;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  mbox_xclk_top #(.DATA_W(DW)) dut_i (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_cs_n(w_cs_n), .wr_en(w_en),
    .wr_dir(w_dir), .wr_sel(w_sel), .wr_data(w_data), .wr_mail_n(wr_mail_n),
    .rd_clk(rd_clk), .rd_cs_n(r_cs_n), .rd_en(r_en), .rd_dir(r_dir),
    .rd_sel(r_sel), .fifo_q(f_q), .rd_data(rd_data), .rd_mail_n(rd_mail_n)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference
  bit m_wr_pend = 0, m_rd_pend = 0;
  logic [DW-1:0] m_mail = '0, m_shadow = '0;
  bit set_infl = 0, ack_infl = 0;
  realtime set_t = 0, ack_t = 0;
  int set_n = 0, ack_n = 0;

  task automatic check1(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $realtime);
    end
  endtask

  always @(negedge rst_n) begin
    m_wr_pend = 0; m_rd_pend = 0; m_mail = '0; m_shadow = '0;
    set_infl = 0; ack_infl = 0; set_n = 0; ack_n = 0;
  end

  always @(posedge wr_clk) begin : wr_model
    bit fire;
    if (rst_n) begin
      fire = !w_cs_n && w_en && w_dir && w_sel && !m_wr_pend;
      if (ack_infl && $realtime > ack_t) begin
        ack_n++;
        if (ack_n == 3) begin ack_infl = 0; m_wr_pend = 0; end
      end
      if (fire) begin
        m_wr_pend = 1; m_mail = w_data;
        set_infl = 1; set_t = $realtime; set_n = 0;
      end
    end
    #1;
    if (rst_n) check1("R1/R3/R5 writer flag", {35'd0, wr_mail_n}, {35'd0, !m_wr_pend});
  end

  always @(posedge rd_clk) begin : rd_model
    bit take;
    if (rst_n) begin
      take = !r_cs_n && r_en && r_dir && r_sel && m_rd_pend;
      if (take) begin
        m_rd_pend = 0; ack_infl = 1; ack_t = $realtime; ack_n = 0;
      end
      if (set_infl && $realtime > set_t) begin
        set_n++;
        if (set_n == 3) begin set_infl = 0; m_rd_pend = 1; m_shadow = m_mail; end
      end
    end
    #1;
    if (rst_n) begin
      check1("R2/R4/R9 reader flag", {35'd0, rd_mail_n}, {35'd0, !m_rd_pend});
      check1("R6/R7 reader data", rd_data, r_sel ? m_shadow : f_q);
    end
  end

  task automatic wr_op(input logic cs_n, en, dir, sel, input logic [DW-1:0] d);
    @(posedge wr_clk); #2;
    w_cs_n = cs_n; w_en = en; w_dir = dir; w_sel = sel; w_data = d;
    @(posedge wr_clk); #2;
    w_cs_n = 1'b1; w_en = 1'b0;
  endtask

  task automatic rd_op(input logic sel, input logic [DW-1:0] fq);
    @(posedge rd_clk); #2;
    r_cs_n = 1'b0; r_en = 1'b1; r_dir = 1'b1; r_sel = sel; f_q = fq;
    @(posedge rd_clk); #2;
    r_cs_n = 1'b1; r_en = 1'b0;
  endtask

  task automatic peek(input logic sel, input logic [DW-1:0] fq);
    @(posedge rd_clk); #2;
    r_sel = sel; f_q = fq;
    @(posedge rd_clk); #1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, run incomplete");
      finish_run();
    end
  end

  initial begin
    r_sel = 1'b1;
    repeat (3) @(posedge wr_clk);
    #0.5;
    check1("R8 writer flag in reset", {35'd0, wr_mail_n}, 36'd1);
    check1("R8 reader flag in reset", {35'd0, rd_mail_n}, 36'd1);
    check1("R8 stored word in reset", rd_data, '0);
    @(posedge wr_clk); #1.2 rst_n = 1'b1;

    // non-qualifying writer accesses (R1)
    wr_op(1'b1, 1'b1, 1'b1, 1'b1, 36'h111111111);
    wr_op(1'b0, 1'b0, 1'b1, 1'b1, 36'h222222222);
    wr_op(1'b0, 1'b1, 1'b0, 1'b1, 36'h333333333);
    wr_op(1'b0, 1'b1, 1'b1, 1'b0, 36'h444444444);
    repeat (6) @(posedge rd_clk);
    peek(1'b1, 36'h0);
    check1("R1 ignored writes leave reader flag", {35'd0, rd_mail_n}, 36'd1);
    check1("R1 ignored writes leave word", rd_data, '0);

    // valid write, delivery (R1, R2)
    wr_op(1'b0, 1'b1, 1'b1, 1'b1, 36'hA5A5A5A5A);
    #0.5 check1("R1 writer flag after write", {35'd0, wr_mail_n}, 36'd0);
    repeat (6) @(posedge rd_clk);
    peek(1'b1, 36'h0);
    check1("R2 reader flag low", {35'd0, rd_mail_n}, 36'd0);
    check1("R2 delivered word", rd_data, 36'hA5A5A5A5A);

    // write while pending is blocked (R3)
    wr_op(1'b0, 1'b1, 1'b1, 1'b1, 36'h0BADBADBA);
    repeat (6) @(posedge rd_clk);
    peek(1'b1, 36'h0);
    check1("R3 blocked write keeps word", rd_data, 36'hA5A5A5A5A);

    // FIFO path selected, read with sel low does not take mail (R6)
    rd_op(1'b0, 36'h123456789);
    #0.5 check1("R6 fifo word shown", rd_data, 36'h123456789);
    peek(1'b0, 36'h987654321);
    check1("R6 mail still waiting", {35'd0, rd_mail_n}, 36'd0);

    // take the mail (R4, R5, R7)
    rd_op(1'b1, 36'h0);
    #0.5 check1("R4 reader flag released", {35'd0, rd_mail_n}, 36'd1);
    check1("R7 word held after take", rd_data, 36'hA5A5A5A5A);
    repeat (6) @(posedge wr_clk);
    #1 check1("R5 writer flag released", {35'd0, wr_mail_n}, 36'd1);

    // read while no mail (R9)
    rd_op(1'b1, 36'h0);
    #0.5 check1("R9 idle read keeps flag", {35'd0, rd_mail_n}, 36'd1);
    check1("R9 idle read returns old word", rd_data, 36'hA5A5A5A5A);
    repeat (4) @(posedge wr_clk);
    #1 check1("R9 writer flag untouched", {35'd0, wr_mail_n}, 36'd1);

    // reset with a word in flight (R8)
    wr_op(1'b0, 1'b1, 1'b1, 1'b1, 36'hFEEDC0DE1);
    @(posedge wr_clk); #1.2 rst_n = 1'b0;
    #0.3;
    check1("R8 writer flag after reset", {35'd0, wr_mail_n}, 36'd1);
    check1("R8 reader flag after reset", {35'd0, rd_mail_n}, 36'd1);
    r_sel = 1'b1; #0.1;
    check1("R8 word cleared", rd_data, '0);
    repeat (8) @(posedge wr_clk);
    #1.2 rst_n = 1'b1;
    repeat (8) @(posedge rd_clk);
    peek(1'b1, 36'h0);
    check1("R8 no stale mail after reset", {35'd0, rd_mail_n}, 36'd1);

    // new round trip after reset (R2)
    wr_op(1'b0, 1'b1, 1'b1, 1'b1, 36'h0C0FFEE00);
    repeat (6) @(posedge rd_clk);
    peek(1'b1, 36'h0);
    check1("R2 delivery after reset", rd_data, 36'h0C0FFEE00);

    // stress: strobes held on both ports, the reference compares every edge
    fork
      begin
        for (int k = 0; k < 300; k++) begin
          @(posedge wr_clk); #2;
          w_cs_n = 1'b0; w_en = 1'b1; w_dir = 1'b1;
          w_sel = ($urandom % 5) != 0;
          w_data = {4'h5, 32'(k)};
        end
        @(posedge wr_clk); #2 w_cs_n = 1'b1; w_en = 1'b0;
      end
      begin
        for (int k = 0; k < 220; k++) begin
          @(posedge rd_clk); #2;
          r_cs_n = ($urandom % 4) == 0; r_en = 1'b1; r_dir = 1'b1;
          r_sel = ($urandom % 3) != 0;
          f_q = {$urandom, 4'h9};
        end
        @(posedge rd_clk); #2 r_cs_n = 1'b1; r_en = 1'b0;
      end
    join
    repeat (10) @(posedge rd_clk);
    #1;
    done = 1;
    finish_run();
  end
endmodule